// File: doc/BRIEF.md
# Two-Layer Pixel Alpha Blender

This block is one compositor stage. Each clock it takes a foreground pixel and a background pixel and returns one blended 8-bit-per-channel RGB pixel. Handshaking is valid/ready on both sides, and the stage runs at one pixel per clock while the downstream side accepts. Red, green and blue are each mixed separately from an effective alpha.

That effective alpha always includes a constant plane alpha. Depending on the blend mode, it may also include the foreground pixel's own alpha. There are three modes:

- **Alpha-ignore:** only the plane alpha is used.
- **Straight (coverage):** the foreground colour is scaled inside the block.
- **Pre-multiplied:** the foreground colour is assumed to be scaled already, and this is the mode after reset.

Internally each mode is decoded into two controls: an alpha-source select and a pre-multiplied flag.

The mode and plane alpha are staged. They only take effect on a frame-start strobe, so settings never change in the middle of a frame.

Top module: `alpha_blend_stage`

## Requirements
- R1: Pixels are 32-bit words laid out as {A[31:24], R[23:16], G[15:8], B[7:0]}. The output alpha byte is always 0xFF.
- R2: `mode_sel` 2'b00 selects alpha-ignore: each channel is S(pa, fg) + S(255 - pa, bg), and the foreground alpha byte has no effect.
- R3: `mode_sel` 2'b10 selects straight alpha. With e = S(pa, fa), each channel is S(e, fg) + S(255 - e, bg).
- R4: `mode_sel` 2'b01 and 2'b11 select pre-multiplied. With e = S(pa, fa), each channel is S(pa, fg) + S(255 - e, bg), and any sum above 255 saturates to 255.
- R5: S(x, y) is x*y/255 rounded to the nearest integer (for example, S(128, 1) = 1).
- R6: After reset `out_valid` is 0 and `in_ready` is 1. The active settings are pre-multiplied mode with plane alpha 255.
- R7: A pixel accepted in cycle c appears on the output in cycle c+3 when `out_ready` stays high. The block accepts one pixel per clock.
- R8: While `out_valid` is high and `out_ready` is low, `out_argb` and `out_valid` hold and `in_ready` is low. No accepted pixel is lost or duplicated.
- R9: `mode_sel` and `plane_alpha` are captured only on a clock edge where `frame_start` is high. A pixel accepted on that same edge still uses the earlier settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Strobe that loads the staged settings |
| mode_sel | input | 2 | Staged blend mode code |
| plane_alpha | input | 8 | Staged constant plane alpha (255 = opaque) |
| in_valid | input | 1 | Input pixel pair valid |
| in_ready | output | 1 | Stage can accept a pixel pair |
| fg_argb | input | 32 | Foreground pixel, ARGB |
| bg_argb | input | 32 | Background pixel, ARGB (alpha unused) |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the output |
| out_argb | output | 32 | Blended pixel, alpha forced to 0xFF |

## Verification
The hardest situation to reach is a settings change that lands while pixels are still in flight and the output is stalled. Correct behaviour requires two things at once: pixels accepted before the strobe still carry the old settings through the stall, and the pixel accepted on the strobe edge also keeps them. The stimulus reaches this by running long stretches where input valid, output ready, the mode code, the plane alpha and the strobe are all random and independent. The mode code and plane alpha also change on many cycles where the strobe is low. A behavioural queue model tags every accepted pixel with the settings active at acceptance.

// File: rtl/blend_pkg.sv
`timescale 1ns/1ps
// Package: shared mode codes for the alpha blender.
// Assumes a 2-bit mode field; code 2'b11 is an alias of pre-multiplied.
package blend_pkg;
    typedef enum logic [1:0] {
        BM_IGNORE    = 2'b00,
        BM_PREMUL    = 2'b01,
        BM_STRAIGHT  = 2'b10,
        BM_PREMUL_B  = 2'b11
    } blend_mode_e;
endpackage

// File: rtl/blend_scale.sv
`timescale 1ns/1ps
// blend_scale: combinational y = round(a*b / MAX) with MAX = 2**CW - 1.
// Assumes both operands are at most MAX; the fold-and-shift form is exact there.
module blend_scale #(
    parameter int CW = 8
) (
    input  logic [CW-1:0] a,
    input  logic [CW-1:0] b,
    output logic [CW-1:0] y
);
    localparam int PW   = 2 * CW + 1;
    localparam int HALF = 1 << (CW - 1);

    logic [PW-1:0] prod, biased, folded;

    // Product, rounding bias, then divide by MAX as (t + t>>CW) >> CW.
    always_comb begin
        prod   = PW'(a) * PW'(b);
        biased = prod + PW'(HALF);
        folded = biased + (biased >> CW);
        y      = folded[2*CW-1:CW];
    end
endmodule

// File: rtl/blend_cfg_shadow.sv
`timescale 1ns/1ps
// blend_cfg_shadow: holds the active blend settings. The mode code is decoded
// into an alpha-source select and a pre-multiplied flag. New values are
// loaded only when frame_start is high. Reset gives pre-multiplied, alpha = MAX.
module blend_cfg_shadow
    import blend_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic [1:0]    mode_in,
    input  logic [CW-1:0] alpha_in,
    output logic          per_pixel,
    output logic          premul,
    output logic [CW-1:0] plane_a
);
    localparam logic [CW-1:0] AMAX = '1;

    logic pp_d, pm_d;

    // Decode the mode code into the two internal controls.
    always_comb begin
        case (blend_mode_e'(mode_in))
            BM_IGNORE:   begin pp_d = 1'b0; pm_d = 1'b0; end
            BM_STRAIGHT: begin pp_d = 1'b1; pm_d = 1'b0; end
            default:     begin pp_d = 1'b1; pm_d = 1'b1; end
        endcase
    end

    // Load the staged settings on the frame strobe only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_pixel <= 1'b1;
            premul    <= 1'b1;
            plane_a   <= AMAX;
        end else if (frame_start) begin
            per_pixel <= pp_d;
            premul    <= pm_d;
            plane_a   <= alpha_in;
        end
    end

    // R6
    reset_default_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (per_pixel && premul && plane_a == AMAX));

    // R9
    settings_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(per_pixel) && $stable(premul) && $stable(plane_a)));
endmodule

// File: rtl/blend_alpha_front.sv
`timescale 1ns/1ps
// blend_alpha_front: pipeline stage 1. Forms the effective alpha (plane alpha,
// or plane alpha times pixel alpha) and the foreground colour scale
// (plane alpha if the colour is already pre-multiplied, else the effective alpha).
// Assumes a shared stall enable for the whole pipeline.
module blend_alpha_front #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          per_pixel,
    input  logic          premul,
    input  logic [CW-1:0] plane_a,
    input  logic [CW-1:0] fg_a,
    output logic [CW-1:0] eff_a_q,
    output logic [CW-1:0] fg_scale_q
);
    logic [CW-1:0] joint_a, eff_a_d, fg_scale_d;

    blend_scale #(.CW(CW)) u_joint (.a(plane_a), .b(fg_a), .y(joint_a));

    // Choose the alpha source and the foreground scale.
    always_comb begin
        eff_a_d    = per_pixel ? joint_a : plane_a;
        fg_scale_d = premul ? plane_a : eff_a_d;
    end

    // Register stage 1 when the pipeline advances.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eff_a_q    <= '0;
            fg_scale_q <= '0;
        end else if (en) begin
            eff_a_q    <= eff_a_d;
            fg_scale_q <= fg_scale_d;
        end
    end

    // R2
    global_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !per_pixel) |=> (eff_a_q == $past(plane_a)));
endmodule

// File: rtl/blend_channel.sv
`timescale 1ns/1ps
// blend_channel: pipeline stages 2 and 3 for one colour channel.
// Stage 2 scales the foreground and background terms; stage 3 adds them
// and saturates at MAX. Assumes the same stall enable as stage 1.
module blend_channel #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [CW-1:0] eff_a,
    input  logic [CW-1:0] fg_scale,
    input  logic [CW-1:0] fg_c,
    input  logic [CW-1:0] bg_c,
    output logic [CW-1:0] y_q
);
    localparam logic [CW-1:0] AMAX = '1;

    logic [CW-1:0] fg_term, bg_term, fg_term_q, bg_term_q, inv_a;
    logic [CW:0]   sum;

    assign inv_a = AMAX - eff_a;

    blend_scale #(.CW(CW)) u_fg (.a(fg_scale), .b(fg_c), .y(fg_term));
    blend_scale #(.CW(CW)) u_bg (.a(inv_a),    .b(bg_c), .y(bg_term));

    assign sum = {1'b0, fg_term_q} + {1'b0, bg_term_q};

    // Stage 2: hold the two scaled terms.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fg_term_q <= '0;
            bg_term_q <= '0;
        end else if (en) begin
            fg_term_q <= fg_term;
            bg_term_q <= bg_term;
        end
    end

    // Stage 3: sum with saturation.
    always_ff @(posedge clk) begin
        if (!rst_n)  y_q <= '0;
        else if (en) y_q <= sum[CW] ? AMAX : sum[CW-1:0];
    end
endmodule

// File: rtl/alpha_blend_stage.sv
`timescale 1ns/1ps
// alpha_blend_stage: top of the two-layer blender. A three-stage pipeline
// with one shared enable, so a stalled output freezes every stage and no
// data is dropped. Assumes ARGB words of 4*CW bits with alpha in the top CW.
module alpha_blend_stage #(
    parameter int CW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_start,
    input  logic [1:0]      mode_sel,
    input  logic [CW-1:0]   plane_alpha,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [4*CW-1:0] fg_argb,
    input  logic [4*CW-1:0] bg_argb,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [4*CW-1:0] out_argb
);
    localparam int STAGES = 3;
    localparam int NCH    = 3;
    localparam logic [CW-1:0] AMAX = '1;

    logic              adv;
    logic [STAGES-1:0] vld;
    logic              cfg_pp, cfg_pm;
    logic [CW-1:0]     cfg_pa, eff_a_q, fg_scale_q;
    logic [NCH*CW-1:0] fg_rgb_q, bg_rgb_q, rgb_out;

    assign adv       = !vld[STAGES-1] || out_ready;
    assign in_ready  = adv;
    assign out_valid = vld[STAGES-1];
    assign out_argb  = {AMAX, rgb_out};

    blend_cfg_shadow #(.CW(CW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .mode_in(mode_sel), .alpha_in(plane_alpha),
        .per_pixel(cfg_pp), .premul(cfg_pm), .plane_a(cfg_pa)
    );

    blend_alpha_front #(.CW(CW)) u_front (
        .clk(clk), .rst_n(rst_n), .en(adv),
        .per_pixel(cfg_pp), .premul(cfg_pm), .plane_a(cfg_pa),
        .fg_a(fg_argb[4*CW-1:3*CW]),
        .eff_a_q(eff_a_q), .fg_scale_q(fg_scale_q)
    );

    // Valid bits travel alongside the data stages.
    always_ff @(posedge clk) begin
        if (!rst_n)   vld <= '0;
        else if (adv) vld <= {vld[STAGES-2:0], in_valid};
    end

    // Stage 1 colour capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fg_rgb_q <= '0;
            bg_rgb_q <= '0;
        end else if (adv) begin
            fg_rgb_q <= fg_argb[NCH*CW-1:0];
            bg_rgb_q <= bg_argb[NCH*CW-1:0];
        end
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        blend_channel #(.CW(CW)) u_chan (
            .clk(clk), .rst_n(rst_n), .en(adv),
            .eff_a(eff_a_q), .fg_scale(fg_scale_q),
            .fg_c(fg_rgb_q[ch*CW +: CW]), .bg_c(bg_rgb_q[ch*CW +: CW]),
            .y_q(rgb_out[ch*CW +: CW])
        );
    end

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_argb)));

    // R7
    accept_enters_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> vld[0]);
endmodule

// File: tb/alpha_blend_stage_test.sv
`timescale 1ns/1ps
module alpha_blend_stage_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic [1:0]  mode_sel = 2'b00;
    logic [7:0]  plane_alpha = 8'd0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] fg_argb = '0;
    logic [31:0] bg_argb = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_argb;

    always #2.5 clk = ~clk;

    alpha_blend_stage uut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .mode_sel(mode_sel), .plane_alpha(plane_alpha),
        .in_valid(in_valid), .in_ready(in_ready),
        .fg_argb(fg_argb), .bg_argb(bg_argb),
        .out_valid(out_valid), .out_ready(out_ready), .out_argb(out_argb)
    );

    typedef struct {
        logic [31:0] exp;
        string       tag;
        int          acc;
        bit          lat;
    } ent_t;

    ent_t        q[$];
    int          compared = 0;
    int          mismatched = 0;
    int          cyc = 0;
    int          act_mode = 1;
    int          act_pa = 255;
    string       phase_tag = "R6";
    bit          lat_chk = 1'b0;
    bit          hold_prev = 1'b0;
    logic [31:0] prev_out = '0;
    bit          done = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Rounded x*y/255 written with integer arithmetic (R5).
    function automatic int sc(input int x, input int y);
        return (2 * x * y + 255) / 510;
    endfunction

    function automatic logic [31:0] model(input int m, input int pa, input logic [31:0] f, input logic [31:0] b);
        int fa, ea, fs, v;
        logic [31:0] r;
        fa = int'(f[31:24]);
        if (m == 0)      begin ea = pa;         fs = pa; end   // R2
        else if (m == 2) begin ea = sc(pa, fa); fs = ea; end   // R3
        else             begin ea = sc(pa, fa); fs = pa; end   // R4
        r = 32'hFF00_0000;                                     // R1
        for (int k = 0; k < 3; k++) begin
            v = sc(fs, int'(f[8*k +: 8])) + sc(255 - ea, int'(b[8*k +: 8]));
            if (v > 255) v = 255;
            r[8*k +: 8] = 8'(v);
        end
        return r;
    endfunction

    // Reference model, compared every clock in mid-cycle.
    always @(negedge clk) begin
        if (!rst_n) begin
            act_mode  = 1;
            act_pa    = 255;
            hold_prev = 1'b0;
            q.delete();
        end else begin
            cyc++;
            if (hold_prev)
                check(out_valid && out_argb == prev_out, "R8 hold", out_argb, prev_out);
            if (out_valid && out_ready) begin
                if (q.size() == 0) begin
                    check(1'b0, "R8 extra output", out_argb, 32'h0);
                end else begin
                    ent_t e;
                    e = q.pop_front();
                    check(out_argb == e.exp, e.tag, out_argb, e.exp);
                    check(out_argb[31:24] == 8'hFF, "R1 alpha", {24'h0, out_argb[31:24]}, 32'hFF);
                    if (e.lat)
                        check(cyc - e.acc == 3, "R7 latency", 32'(cyc - e.acc), 32'd3);
                end
            end
            if (in_valid && in_ready) begin
                ent_t n;
                n.exp = model(act_mode, act_pa, fg_argb, bg_argb);
                n.tag = phase_tag;
                n.acc = cyc;
                n.lat = lat_chk;
                q.push_back(n);
            end
            if (frame_start) begin
                act_mode = int'(mode_sel);
                act_pa   = int'(plane_alpha);
            end
            hold_prev = out_valid && !out_ready;
            prev_out  = out_argb;
        end
    end

    task automatic step(input bit v, input logic [31:0] f, input logic [31:0] b, input bit r,
                        input bit fs, input logic [1:0] m, input logic [7:0] pa);
        @(posedge clk);
        #1;
        in_valid = v; fg_argb = f; bg_argb = b; out_ready = r;
        frame_start = fs; mode_sel = m; plane_alpha = pa;
    endtask

    task automatic strobe(input logic [1:0] m, input logic [7:0] pa);
        step(1'b0, '0, '0, 1'b1, 1'b1, m, pa);
    endtask

    task automatic stream(input int n);
        for (int i = 0; i < n; i++)
            step(1'b1, $urandom, $urandom, 1'b1, 1'b0, 2'($urandom), 8'($urandom));
    endtask

    task automatic drain();
        for (int i = 0; i < 8; i++)
            step(1'b0, '0, '0, 1'b1, 1'b0, mode_sel, plane_alpha);
    endtask

    task automatic rand_run(input int n, input int vp, input int rp, input int sp);
        for (int i = 0; i < n; i++)
            step(($urandom % 100) < vp, $urandom, $urandom, ($urandom % 100) < rp,
                 ($urandom % 100) < sp, 2'($urandom), 8'($urandom));
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R6: reset state at the ports
        check(!out_valid && in_ready, "R6 reset", {30'h0, out_valid, in_ready}, 32'h1);

        // R6 defaults with no strobe yet; R7 latency at full throughput
        lat_chk = 1'b1;
        phase_tag = "R6";
        stream(6);
        drain();

        phase_tag = "R2";
        strobe(2'b00, 8'd128);
        stream(20);
        drain();

        phase_tag = "R5";
        strobe(2'b00, 8'd128);
        step(1'b1, 32'h0001_0101, 32'h0, 1'b1, 1'b0, 2'b00, 8'd0);
        step(1'b1, 32'hFF02_0304, 32'h0000_0001, 1'b1, 1'b0, 2'b00, 8'd0);
        drain();

        phase_tag = "R3";
        strobe(2'b10, 8'd200);
        stream(20);
        drain();

        phase_tag = "R4";
        strobe(2'b01, 8'd255);
        step(1'b1, 32'h00FF_FFFF, 32'h00FF_FFFF, 1'b1, 1'b0, 2'b00, 8'd0);
        step(1'b1, 32'h80FF_80FF, 32'h00FF_FF00, 1'b1, 1'b0, 2'b00, 8'd0);
        stream(20);
        strobe(2'b11, 8'd90);
        stream(20);
        drain();

        // R9: strobe on the same edge as an accepted pixel, then settings churn
        phase_tag = "R9";
        step(1'b1, 32'h40C0_C0C0, 32'h0010_2030, 1'b1, 1'b1, 2'b00, 8'd10);
        step(1'b1, 32'h40C0_C0C0, 32'h0010_2030, 1'b1, 1'b0, 2'b10, 8'd250);
        drain();
        lat_chk = 1'b0;

        phase_tag = "R8";
        rand_run(300, 80, 40, 0);
        drain();

        phase_tag = "R9";
        rand_run(600, 70, 60, 4);
        drain();

        check(q.size() == 0, "R8 lost pixels", 32'(q.size()), 32'd0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog actual %0d expected done", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule